// File: doc/BRIEF.md
# Register Hazard Scoreboard with Result Forwarding

This block guards the operand reads of a short in-order integer pipeline. Each cycle the decode stage offers one instruction: up to three source register numbers, each with its own valid bit, plus an optional destination with a flag saying whether the result will come straight from the integer execute unit ("fast") or from a slower path such as load/store or the cache. The scoreboard keeps a small ordered list of destinations that have issued but not yet been written back. For each source it decides whether the read is safe, whether it needs the result of the instruction issued in the cycle just before, or whether decode must hold.

If forwarding is possible, the per-operand select is set and the instruction issues. The selects are registered with the instruction as it enters execute, and they drive a three-way operand multiplexer. Each leg of the multiplexer picks either the register-read data or the result that the execute stage latched for the previous instruction. Any other hazard stalls decode until write-back removes the entry. Write-back removes the oldest pending entry for the written register, and that removal is visible to the hazard check in the same cycle.

Top module: `gprh_top`

## Requirements
- R1: Reset clears every pending entry. After reset, a read of any register neither stalls nor forwards, even if that register was pending before reset.
- R2: When a read hits the newest pending entry, that entry is fast, and its producer issued on the immediately preceding clock, the operand's forward select (`iss_fwd_sel` bit i for source i) is 1 and the read causes no stall.
- R3: A read of a pending register whose newest entry is not fast holds `stall` high. Write-back of a different register leaves `stall` high. `stall` falls in the same cycle that `wb_valid` presents the pending register.
- R4: A read of a fast entry whose producer did not issue on the immediately preceding clock (an idle or stalled cycle came between them) stalls.
- R5: On the clock after an instruction issues (`iss_valid` high, `stall` low), `exe_valid` is 1 and `exe_fwd_sel` equals the `iss_fwd_sel` of that cycle. After a stalled or idle cycle, `exe_valid` is 0 and `exe_fwd_sel` is 0.
- R6: For each operand i, `exe_opnd[i]` equals `exe_result` when `exe_fwd_sel[i]` is 1, and `rf_data[i]` otherwise.
- R7: The list holds DEPTH (default 2) outstanding writes. An instruction with a destination stalls while the list is full, unless a write-back in the same cycle frees an entry.
- R8: A source whose valid bit is 0 never stalls and never forwards.
- R9: Register 0 is tracked exactly like every other register.
- R10: A write-back of a register that is not pending has no effect. Pending entries stay pending.
- R11: When the same register is pending twice, the newest entry decides. A fast producer from the preceding clock forwards, even though an older slow entry for that register is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Decode offers an instruction |
| iss_src_valid | input | NSRC (3) | Per-source read enable |
| iss_src_reg | input | NSRC x log2(NREG) | Source register numbers |
| iss_dst_valid | input | 1 | Instruction writes a register |
| iss_dst_reg | input | log2(NREG) | Destination register number |
| iss_dst_fast | input | 1 | Result comes from the integer execute unit |
| wb_valid | input | 1 | A register is written back this cycle |
| wb_reg | input | log2(NREG) | Register being written back |
| stall | output | 1 | Decode must hold the offered instruction |
| iss_fwd_sel | output | NSRC | Combinational per-source forward decision |
| exe_valid | output | 1 | Execute stage holds an issued instruction |
| exe_fwd_sel | output | NSRC | Registered forward selects for the execute stage |
| rf_data | input | NSRC x DW | Register-read data for the instruction in execute |
| exe_result | input | DW | Latched result of the previous execute-stage instruction |
| exe_opnd | output | NSRC x DW | Selected operands for execute |

## Verification
The hardest cases to reach are those where the list already holds two entries with particular ages and kinds. Examples are two pending entries for one register with different kinds, or a fast entry that has aged by a single idle cycle. The stimulus table walks through issue sequences that build exactly those lists. Write-back is then timed to the same cycle as a blocked read or a full-list issue, so the same-cycle release and the oldest-first removal can both be seen at the ports.

// File: rtl/gprh_pkg.sv
// Shared types of the register hazard scoreboard.
// Assumes: nothing beyond IEEE 1800-2017.
package gprh_pkg;

    // Source of one execute-stage operand.
    typedef enum logic {
        OPND_FROM_RF  = 1'b0,
        OPND_FROM_EXE = 1'b1
    } opnd_src_e;

    // Verdict for one source operand.
    typedef struct packed {
        logic fwd;   // take the value from the execute output
        logic blk;   // operand cannot be read yet
    } opnd_verdict_t;

endpackage

// File: rtl/gprh_store.sv
// Ordered list of pending destination registers, oldest in slot 0.
// Write-back removes the oldest matching entry and compacts the list;
// issue appends after the removal. The "view" outputs show the list
// after this cycle's removal and before the append, so hazard checks
// see a same-cycle write-back.
// Assumes: wr_en is only raised when view_cnt < DEPTH.
module gprh_store #(
    parameter int NREG  = 32,
    parameter int DEPTH = 2,
    localparam int AW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_reg,
    input  logic                      wr_fast,
    input  logic                      wb_valid,
    input  logic [AW-1:0]             wb_reg,
    output logic [CW-1:0]             view_cnt,
    output logic [DEPTH-1:0][AW-1:0]  view_reg,
    output logic [DEPTH-1:0]          view_fast,
    output logic [DEPTH-1:0]          view_last
);

    logic [CW-1:0]             cnt_q;
    logic [DEPTH-1:0][AW-1:0]  reg_q, reg_n;
    logic [DEPTH-1:0]          fast_q, fast_n;
    logic [DEPTH-1:0]          last_q, last_n;
    logic                      kill;
    logic [IW-1:0]             kill_idx;

    // Pick the oldest pending entry named by the write-back.
    always_comb begin
        kill     = 1'b0;
        kill_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (wb_valid && (CW'(i) < cnt_q) && (reg_q[i] == wb_reg)) begin
                kill     = 1'b1;
                kill_idx = IW'(i);
            end
        end
    end

    assign view_cnt = cnt_q - CW'(kill);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Compact: slots at or above the removed one take their upper neighbour.
        if (g < DEPTH - 1) begin : g_shift
            always_comb begin
                if (kill && (IW'(g) >= kill_idx)) begin
                    view_reg[g]  = reg_q[g+1];
                    view_fast[g] = fast_q[g+1];
                    view_last[g] = last_q[g+1];
                end else begin
                    view_reg[g]  = reg_q[g];
                    view_fast[g] = fast_q[g];
                    view_last[g] = last_q[g];
                end
            end
        end else begin : g_top
            always_comb begin
                view_reg[g]  = reg_q[g];
                view_fast[g] = fast_q[g];
                view_last[g] = last_q[g];
            end
        end

        // Append the issuing destination; every older entry loses "last".
        always_comb begin
            if (wr_en && (view_cnt == CW'(g))) begin
                reg_n[g]  = wr_reg;
                fast_n[g] = wr_fast;
                last_n[g] = 1'b1;
            end else begin
                reg_n[g]  = view_reg[g];
                fast_n[g] = view_fast[g];
                last_n[g] = 1'b0;
            end
        end
    end

    // Hold the list state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            reg_q  <= '0;
            fast_q <= '0;
            last_q <= '0;
        end else begin
            cnt_q  <= view_cnt + CW'(wr_en);
            reg_q  <= reg_n;
            fast_q <= fast_n;
            last_q <= last_n;
        end
    end

    // R7: an append never lands in a full list
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (view_cnt < CW'(DEPTH)));

    // R3: a matching write-back without an append shrinks the list by one
    p_wb_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R1: reset empties the list
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

endmodule

// File: rtl/gprh_lookup.sv
// Hazard verdict for one source operand against the pending list view.
// Forward only from the newest entry when it is fast and was appended on
// the previous clock; any other match blocks.
// Assumes: view entries at index >= view_cnt are not meaningful.
module gprh_lookup
    import gprh_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int DEPTH = 2,
    localparam int AW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      src_valid,
    input  logic [AW-1:0]             src_reg,
    input  logic [CW-1:0]             view_cnt,
    input  logic [DEPTH-1:0][AW-1:0]  view_reg,
    input  logic [DEPTH-1:0]          view_fast,
    input  logic [DEPTH-1:0]          view_last,
    output opnd_verdict_t             verdict
);

    logic [DEPTH-1:0] hit;
    logic             hit_newest_ok;

    // Match the source against every live entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = src_valid && (CW'(i) < view_cnt) && (view_reg[i] == src_reg);
        end
    end

    // Check whether the newest entry can supply the value directly.
    always_comb begin
        hit_newest_ok = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) + CW'(1)) == view_cnt) begin
                hit_newest_ok = hit[i] && view_fast[i] && view_last[i];
            end
        end
    end

    assign verdict.fwd = hit_newest_ok;
    assign verdict.blk = (|hit) && !hit_newest_ok;

endmodule

// File: rtl/gprh_opnd_mux.sv
// Execute-stage operand selection: register-read data or the latched
// result of the previous execute-stage instruction.
// Assumes: rf_data already belongs to the instruction now in execute.
module gprh_opnd_mux
    import gprh_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int DW   = 64
) (
    input  logic [NSRC-1:0]          sel,
    input  logic [NSRC-1:0][DW-1:0]  rf_data,
    input  logic [DW-1:0]            exe_result,
    output logic [NSRC-1:0][DW-1:0]  opnd
);

    for (genvar g = 0; g < NSRC; g++) begin : g_leg
        opnd_src_e src;
        assign src = opnd_src_e'(sel[g]);
        // Choose this leg's operand source.
        always_comb begin
            case (src)
                OPND_FROM_EXE: opnd[g] = exe_result;
                default:       opnd[g] = rf_data[g];
            endcase
        end
    end

endmodule

// File: rtl/gprh_top.sv
// Register hazard scoreboard with forwarding for an in-order pipeline.
// Decides per cycle whether the offered instruction issues, registers
// its forward selects into the execute stage and drives the operand mux.
// Assumes: write-back is in program order per register and the register
// file writes through in the write-back cycle.
module gprh_top
    import gprh_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int NREG  = 32,
    parameter int DEPTH = 2,
    parameter int DW    = 64,
    localparam int AW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [NSRC-1:0]           iss_src_valid,
    input  logic [NSRC-1:0][AW-1:0]   iss_src_reg,
    input  logic                      iss_dst_valid,
    input  logic [AW-1:0]             iss_dst_reg,
    input  logic                      iss_dst_fast,
    input  logic                      wb_valid,
    input  logic [AW-1:0]             wb_reg,
    output logic                      stall,
    output logic [NSRC-1:0]           iss_fwd_sel,
    output logic                      exe_valid,
    output logic [NSRC-1:0]           exe_fwd_sel,
    input  logic [NSRC-1:0][DW-1:0]   rf_data,
    input  logic [DW-1:0]             exe_result,
    output logic [NSRC-1:0][DW-1:0]   exe_opnd
);

    logic [CW-1:0]             view_cnt;
    logic [DEPTH-1:0][AW-1:0]  view_reg;
    logic [DEPTH-1:0]          view_fast;
    logic [DEPTH-1:0]          view_last;
    opnd_verdict_t [NSRC-1:0]  verdict;
    logic [NSRC-1:0]           blk_vec;
    logic                      list_full;
    logic                      issue;
    logic                      wr_en;

    gprh_store #(.NREG(NREG), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_reg    (iss_dst_reg),
        .wr_fast   (iss_dst_fast),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .view_cnt  (view_cnt),
        .view_reg  (view_reg),
        .view_fast (view_fast),
        .view_last (view_last)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        gprh_lookup #(.NREG(NREG), .DEPTH(DEPTH)) u_lookup (
            .src_valid (iss_src_valid[g]),
            .src_reg   (iss_src_reg[g]),
            .view_cnt  (view_cnt),
            .view_reg  (view_reg),
            .view_fast (view_fast),
            .view_last (view_last),
            .verdict   (verdict[g])
        );
        assign blk_vec[g]     = verdict[g].blk;
        assign iss_fwd_sel[g] = iss_valid && verdict[g].fwd;
    end

    // Hold decode on any blocked operand or on a full list.
    always_comb begin
        list_full = (view_cnt == CW'(DEPTH));
        stall     = iss_valid && ((|blk_vec) || (iss_dst_valid && list_full));
    end

    assign issue = iss_valid && !stall;
    assign wr_en = issue && iss_dst_valid;

    // Carry the forward selects into the execute stage with the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exe_valid   <= 1'b0;
            exe_fwd_sel <= '0;
        end else begin
            exe_valid   <= issue;
            exe_fwd_sel <= issue ? iss_fwd_sel : '0;
        end
    end

    gprh_opnd_mux #(.NSRC(NSRC), .DW(DW)) u_mux (
        .sel        (exe_fwd_sel),
        .rf_data    (rf_data),
        .exe_result (exe_result),
        .opnd       (exe_opnd)
    );

    // R5: a held instruction leaves a bubble in execute
    p_stall_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && stall) |=> !exe_valid);

    // R5: selects arrive in execute one clock after issue
    p_sel_travels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall) |=> (exe_valid && (exe_fwd_sel == $past(iss_fwd_sel))));

    // R2: a forwarded operand never causes the stall by itself
    p_fwd_no_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_fwd_sel != '0) && !iss_dst_valid && !(|blk_vec)) |-> !stall);

endmodule

// File: tb/gprh_top_tb.sv
module gprh_top_tb;

    localparam int NSRC = 3;
    localparam int DW   = 64;
    localparam int AW   = 5;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     iss_valid = 1'b0;
    logic [NSRC-1:0]          iss_src_valid = '0;
    logic [NSRC-1:0][AW-1:0]  iss_src_reg = '0;
    logic                     iss_dst_valid = 1'b0;
    logic [AW-1:0]            iss_dst_reg = '0;
    logic                     iss_dst_fast = 1'b0;
    logic                     wb_valid = 1'b0;
    logic [AW-1:0]            wb_reg = '0;
    logic                     stall;
    logic [NSRC-1:0]          iss_fwd_sel;
    logic                     exe_valid;
    logic [NSRC-1:0]          exe_fwd_sel;
    logic [NSRC-1:0][DW-1:0]  rf_data = '0;
    logic [DW-1:0]            exe_result = '0;
    logic [NSRC-1:0][DW-1:0]  exe_opnd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gprh_top u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
        .iss_src_valid(iss_src_valid), .iss_src_reg(iss_src_reg),
        .iss_dst_valid(iss_dst_valid), .iss_dst_reg(iss_dst_reg),
        .iss_dst_fast(iss_dst_fast), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .stall(stall), .iss_fwd_sel(iss_fwd_sel), .exe_valid(exe_valid),
        .exe_fwd_sel(exe_fwd_sel), .rf_data(rf_data),
        .exe_result(exe_result), .exe_opnd(exe_opnd)
    );

    typedef struct packed {
        logic       iv;
        logic [2:0] sv;
        logic [4:0] s0, s1, s2;
        logic       dv;
        logic [4:0] dr;
        logic       df;
        logic       wv;
        logic [4:0] wr;
        logic       es;
        logic [2:0] ef;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        // iv sv     s0 s1 s2  dv dr df  wv wr  es ef
        '{1, 3'b001, 5, 0, 0,  0, 0, 0,  0, 0,  0, 3'b000}, // R1 empty after reset
        '{1, 3'b000, 0, 0, 0,  1, 3, 1,  0, 0,  0, 3'b000}, // fast producer r3
        '{1, 3'b011, 3, 3, 0,  1, 4, 0,  0, 0,  0, 3'b011}, // R2 back-to-back forward
        '{1, 3'b001, 4, 0, 0,  0, 0, 0,  0, 0,  1, 3'b000}, // R3 slow entry stalls
        '{1, 3'b001, 4, 0, 0,  0, 0, 0,  1, 3,  1, 3'b000}, // R3 other wb keeps stall
        '{1, 3'b001, 4, 0, 0,  0, 0, 0,  1, 4,  0, 3'b000}, // R3 same-cycle release
        '{1, 3'b000, 0, 0, 0,  1, 0, 1,  0, 0,  0, 3'b000}, // fast producer r0
        '{0, 3'b000, 0, 0, 0,  0, 0, 0,  0, 0,  0, 3'b000}, // idle gap
        '{1, 3'b100, 0, 0, 0,  0, 0, 0,  0, 0,  1, 3'b000}, // R4 R9 aged fast r0 stalls
        '{1, 3'b100, 0, 0, 0,  0, 0, 0,  1, 0,  0, 3'b000}, // R9 wb of r0 releases
        '{1, 3'b000, 0, 0, 0,  1, 7, 0,  0, 0,  0, 3'b000}, // slow r7
        '{1, 3'b000, 0, 0, 0,  1, 7, 1,  0, 0,  0, 3'b000}, // fast r7 on top
        '{1, 3'b010, 0, 7, 0,  0, 0, 0,  0, 0,  0, 3'b010}, // R11 newest decides
        '{1, 3'b000, 0, 0, 0,  1, 9, 1,  0, 0,  1, 3'b000}, // R7 full list stalls
        '{1, 3'b000, 0, 0, 0,  1, 9, 1,  1, 7,  0, 3'b000}, // R7 wb frees a slot
        '{1, 3'b111, 9, 7, 12, 0, 0, 0,  0, 0,  1, 3'b001}, // R4 mixed verdicts
        '{1, 3'b000, 7, 9, 0,  0, 0, 0,  0, 0,  0, 3'b000}, // R8 invalid sources
        '{0, 3'b000, 0, 0, 0,  0, 0, 0,  1, 20, 0, 3'b000}, // R10 wb of idle reg
        '{1, 3'b001, 9, 0, 0,  0, 0, 0,  0, 0,  1, 3'b000}, // R10 r9 still pending
        '{0, 3'b000, 0, 0, 0,  0, 0, 0,  1, 7,  0, 3'b000},
        '{0, 3'b000, 0, 0, 0,  0, 0, 0,  1, 9,  0, 3'b000},
        '{1, 3'b001, 9, 0, 0,  0, 0, 0,  0, 0,  0, 3'b000}  // list drained
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        iss_valid     = v.iv;
        iss_src_valid = v.sv;
        iss_src_reg   = {v.s2, v.s1, v.s0};
        iss_dst_valid = v.dv;
        iss_dst_reg   = v.dr;
        iss_dst_fast  = v.df;
        wb_valid      = v.wv;
        wb_reg        = v.wr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        vec_t idle;
        idle = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R5: reset state of the execute stage
        chk("R1 exe_valid after reset", 64'(exe_valid), 64'd0);
        chk("R5 exe_fwd_sel after reset", 64'(exe_fwd_sel), 64'd0);

        // Table walk: stall and forward decision per cycle
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            drive(VEC[k]);
            #1;
            chk($sformatf("vec %0d stall", k), 64'(stall), 64'(VEC[k].es));
            chk($sformatf("vec %0d fwd", k), 64'(iss_fwd_sel), 64'(VEC[k].ef));
        end

        // R5 / R6: forward selects travel into execute and steer the mux
        @(negedge clk);
        drive(idle);
        iss_valid = 1'b1; iss_dst_valid = 1'b1; iss_dst_reg = 5'd3; iss_dst_fast = 1'b1;
        @(negedge clk);
        drive(idle);
        iss_valid = 1'b1; iss_src_valid = 3'b101; iss_src_reg = {5'd3, 5'd11, 5'd3};
        #1;
        chk("R2 directed fwd", 64'(iss_fwd_sel), 64'(3'b101));
        @(negedge clk);
        drive(idle);
        rf_data    = {64'hC0C0, 64'hB0B0, 64'hA0A0};
        exe_result = 64'h5555_AAAA;
        #1;
        chk("R5 exe_valid after issue", 64'(exe_valid), 64'd1);
        chk("R5 exe_fwd_sel after issue", 64'(exe_fwd_sel), 64'(3'b101));
        chk("R6 opnd0 from exe", exe_opnd[0], 64'h5555_AAAA);
        chk("R6 opnd1 from rf", exe_opnd[1], 64'hB0B0);
        chk("R6 opnd2 from exe", exe_opnd[2], 64'h5555_AAAA);
        @(negedge clk);
        #1;
        chk("R5 exe_valid after idle", 64'(exe_valid), 64'd0);
        chk("R6 opnd0 from rf after idle", exe_opnd[0], 64'hA0A0);

        // R5: a stalled instruction leaves a bubble (r3 still pending, aged)
        drive(idle);
        iss_valid = 1'b1; iss_src_valid = 3'b001; iss_src_reg = {5'd0, 5'd0, 5'd3};
        #1;
        chk("R4 aged r3 stalls", 64'(stall), 64'd1);
        @(negedge clk);
        #1;
        chk("R5 bubble after stall", 64'(exe_valid), 64'd0);

        // R1: reset mid-run drops pending r3 and a new slow r5
        drive(idle);
        iss_valid = 1'b1; iss_dst_valid = 1'b1; iss_dst_reg = 5'd5;
        @(negedge clk);
        drive(idle);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        iss_valid = 1'b1; iss_src_valid = 3'b011; iss_src_reg = {5'd0, 5'd3, 5'd5};
        #1;
        chk("R1 no stall after reset", 64'(stall), 64'd0);
        chk("R1 no fwd after reset", 64'(iss_fwd_sel), 64'd0);
        @(negedge clk);
        drive(idle);
        @(negedge clk);
        finish_run();
    end

endmodule